// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a synchronous static RAM core. Its protocol lets reads and writes follow each other on consecutive clocks with no idle cycle between them. Address, chip selects, the write strobe, the burst-advance strobe and the per-lane byte strobes are sampled on every rising clock edge. Write data does not arrive with its address. It follows one edge later in flow-through mode and two edges later in pipelined mode. Because of this delay, the read data of an earlier read and the write data of a later write use the shared data path in different cycles.

A static mode pin selects the read path. In flow-through mode there is no output register, so a read's data appears in the cycle after its address edge. In pipelined mode an output register adds one more cycle. A read that targets a word whose write is still waiting in the late-write pipeline returns the waiting data, merged lane by lane with the stored word. A burst-advance strobe steps the two low address bits from the last loaded start address. A static pin selects linear or interleaved order. The output enable gates the data outputs asynchronously.

Top module: `lw_sram`

## Requirements
- R1: A non-advance cycle is an access only when `cs_a`, `cs_b` and `cs_c` are all 1. Otherwise it stores nothing, drives no read data, and ends any burst.
- R2: In flow-through mode (`pipe_mode`=0), a read sampled at edge k drives its data on `dout` from edge k until edge k+1.
- R3: In pipelined mode (`pipe_mode`=1), a read sampled at edge k drives its data on `dout` from edge k+1 until edge k+2.
- R4: In flow-through mode, the data for a write sampled at edge k is taken from `din` at edge k+1.
- R5: In pipelined mode, the data for a write sampled at edge k is taken from `din` at edge k+2.
- R6: Reads and writes may be issued on consecutive edges in any mix. Every read returns the correct word, and `dout_en` stays 0 in cycles that carry no read data.
- R7: Lane i is bits [9i+8:9i]. A write changes lane i only if `be[i]`=1 at the edge that sampled its address.
- R8: A read of a word whose write has been sampled but not yet committed returns that pending write's enabled lanes together with the stored values of its other lanes.
- R9: With `ilv_order`=0, the n-th advance cycle (n=1..3) after a start address S accesses the address with low bits (S[1:0]+n) mod 4 and upper bits unchanged. It repeats the start operation, read or write.
- R10: With `ilv_order`=1, the n-th advance cycle accesses the address with low bits S[1:0] XOR n.
- R11: While `oe`=0, `dout_en` is 0 and `dout` is all zeros, without affecting any stored or pending state.
- R12: After a synchronous reset (`rst_n`=0), no read data is driven and no write is pending. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pipe_mode | input | 1 | Static: 1 = pipelined, 0 = flow-through |
| ilv_order | input | 1 | Static: 1 = interleaved burst, 0 = linear |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c | input | 1 | Chip select, active high |
| adv | input | 1 | Burst advance; the address and selects are ignored |
| we | input | 1 | 1 = write, 0 = read (on non-advance cycles) |
| be | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Late write data |
| oe | input | 1 | Asynchronous output enable |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
The assertions check the output timing on every cycle. A selected read must make `dout_en` follow `oe` one edge later in flow-through mode and two edges later in pipelined mode. A low `oe` must silence the outputs. Writes and deselected cycles in flow-through mode must leave the outputs quiet. The data values need the bench's scenarios: the late-write capture edge, lane merging, read-after-write forwarding from the pending stage, and both burst orders. The bench shows these by comparing every read against a cycle-level reference model, in all four combinations of mode and burst order.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              ilv_order,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_c,
  input  logic              adv,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              b_act, b_we;
  logic [ADDR_W-1:0] b_start;
  logic [1:0]        b_cnt;

  wire       sel   = cs_a & cs_b & cs_c;
  wire [1:0] b_stp = b_cnt + 2'd1;
  wire [1:0] b_lo  = ilv_order ? (b_start[1:0] ^ b_stp) : (b_start[1:0] + b_stp);

  wire              act   = adv ? b_act : sel;
  wire              is_wr = adv ? b_we : we;
  wire [ADDR_W-1:0] ea    = adv ? {b_start[ADDR_W-1:2], b_lo} : addr;

  logic              s1_v, s2_v;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;

  wire              wc_v  = pipe_mode ? s2_v  : s1_v;
  wire [ADDR_W-1:0] wc_a  = pipe_mode ? s2_a  : s1_a;
  wire [LANES-1:0]  wc_be = pipe_mode ? s2_be : s1_be;

  logic              r_v, o_v;
  logic [ADDR_W-1:0] r_a;
  logic [DATA_W-1:0] o_d, view;

  wire fwd = wc_v && (wc_a == r_a);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign view[i*LANE_W +: LANE_W] = (fwd && wc_be[i]) ? din[i*LANE_W +: LANE_W]
                                                        : mem[r_a][i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wc_v && wc_be[i]) mem[wc_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act <= 1'b0;
      b_we  <= 1'b0;
      b_cnt <= 2'd0;
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      r_v   <= 1'b0;
      o_v   <= 1'b0;
    end else begin
      if (!adv) begin
        b_act <= sel;
        b_we  <= we;
        b_cnt <= 2'd0;
      end else if (b_act) begin
        b_cnt <= b_stp;
      end
      s1_v <= act & is_wr;
      s2_v <= s1_v;
      r_v  <= act & ~is_wr;
      o_v  <= r_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!adv) b_start <= addr;
    s1_a  <= ea;
    s1_be <= be;
    s2_a  <= s1_a;
    s2_be <= s1_be;
    r_a   <= ea;
    if (r_v) o_d <= view;
  end

  assign dout_en = oe & (pipe_mode ? o_v : r_v);
  assign dout    = dout_en ? (pipe_mode ? o_d : view) : '0;

endmodule

module lw_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              cs_a,
  input logic              cs_b,
  input logic              cs_c,
  input logic              adv,
  input logic              we,
  input logic              oe,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  wire sel_all = cs_a & cs_b & cs_c;
  wire rd0     = !adv && sel_all && !we;

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dout_en && dout == '0)); // R11
  AST_FT_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd0) |=> (dout_en == oe)); // R2
  AST_PL_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd0) |=> ##1 (dout_en == oe)); // R3
  AST_FT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && sel_all && we) |=> !dout_en); // R6
  AST_FT_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && !sel_all) |=> !dout_en); // R1
endmodule

bind lw_sram lw_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs_a(cs_a), .cs_b(cs_b),
  .cs_c(cs_c), .adv(adv), .we(we), .oe(oe), .dout(dout), .dout_en(dout_en)
);

// File: tb/lw_sram_bench.sv
`timescale 1ns/1ps
module lw_sram_bench;
  localparam int AW = 6, LN = 2, LW = 9, DW = LN * LW, DEP = 1 << AW;

  logic clk = 0, rst_n = 0, pipe_mode = 0, ilv_order = 0;
  logic cs_a = 0, cs_b = 0, cs_c = 0, adv = 0, we = 0, oe = 1;
  logic [LN-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_lw_sram (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .adv(adv), .we(we), .be(be),
    .addr(addr), .din(din), .oe(oe), .dout(dout), .dout_en(dout_en));

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0;
  string tag = "R12";

  logic [DW-1:0] mm [DEP];
  logic          pq_v [2];
  logic [AW-1:0] pq_a [2];
  logic [LN-1:0] pq_be [2];
  logic [DW-1:0] pq_d [2];
  logic          ev_v [2];
  logic [DW-1:0] ev_d [2];
  logic          bm_act, bm_we;
  logic [AW-1:0] bm_start;
  int            bm_n;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [LN-1:0] m);
    logic [DW-1:0] r = o;
    for (int i = 0; i < LN; i++) if (m[i]) r[i*LW +: LW] = n[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [1:0] burst_lo(logic [1:0] s, int n, logic ilv);
    return ilv ? (s ^ 2'(n)) : (s + 2'(n));
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin pq_v[i] = 0; ev_v[i] = 0; end
    bm_act = 0; bm_we = 0; bm_n = 0;
  endtask

  task automatic cyc(bit a_adv, logic [2:0] cs, bit a_we, logic [AW-1:0] a,
                     logic [LN-1:0] m, logic [DW-1:0] d, bit a_oe);
    int dl;
    bit eact, ewe, exv;
    logic [AW-1:0] ea;
    logic [DW-1:0] v, exd;
    dl = pipe_mode ? 2 : 1;
    adv = a_adv; {cs_a, cs_b, cs_c} = cs; we = a_we; addr = a; be = m; oe = a_oe;
    din = pq_v[dl-1] ? pq_d[dl-1] : DW'($urandom);
    @(posedge clk);
    // R4 R5: the write whose data is on din commits at this edge
    if (pq_v[dl-1]) mm[pq_a[dl-1]] = merge(mm[pq_a[dl-1]], pq_d[dl-1], pq_be[dl-1]);
    if (dl == 2) begin pq_v[1] = pq_v[0]; pq_a[1] = pq_a[0]; pq_be[1] = pq_be[0]; pq_d[1] = pq_d[0]; end
    pq_v[0] = 0;
    if (!a_adv) begin
      eact = &cs; ewe = a_we; ea = a;
      bm_act = eact; bm_we = a_we; bm_start = a; bm_n = 0;
    end else begin
      eact = bm_act; ewe = bm_we;
      if (bm_act) bm_n++;
      ea = {bm_start[AW-1:2], burst_lo(bm_start[1:0], bm_n, ilv_order)};
    end
    ev_v[1] = ev_v[0]; ev_d[1] = ev_d[0]; ev_v[0] = 0;
    if (eact && ewe) begin pq_v[0] = 1; pq_a[0] = ea; pq_be[0] = m; pq_d[0] = d; end
    if (eact && !ewe) begin
      v = mm[ea];
      if (dl == 2 && pq_v[1] && pq_a[1] == ea) v = merge(v, pq_d[1], pq_be[1]); // R8
      ev_v[0] = 1; ev_d[0] = v;
    end
    @(negedge clk);
    exv = ev_v[dl-1]; exd = ev_d[dl-1];
    chk(dout_en == (exv && a_oe), {tag, pipe_mode ? " R3 dout_en" : " R2 dout_en"},
        DW'(dout_en), DW'(exv && a_oe));
    if (exv && a_oe) chk(dout == exd, {tag, pipe_mode ? " R3 data" : " R2 data"}, dout, exd);
    if (!a_oe) chk(dout == '0, "R11 dout off", dout, '0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 3'b000, 0, '0, '0, '0, 1);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [LN-1:0] m, logic [DW-1:0] d);
    cyc(0, 3'b111, 1, a, m, d, 1);
  endtask

  task automatic rd(logic [AW-1:0] a);
    cyc(0, 3'b111, 0, a, '0, '0, 1);
  endtask

  task automatic phase(bit p, bit i);
    pipe_mode = p; ilv_order = i;
    adv = 0; {cs_a, cs_b, cs_c} = 3'b000; oe = 1;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    model_clear();
    chk(!dout_en, "R12 no drive after reset", DW'(dout_en), '0);
  endtask

  task automatic directed();
    tag = ilv_order ? "R10" : "R9";
    wr(6'h0D, 2'b11, 18'h10001);
    for (int n = 1; n < 4; n++) cyc(1, 3'b000, 0, '0, 2'b11, DW'(18'h10001 + n), 1);
    idle(2);
    for (int n = 0; n < 4; n++) rd({4'h3, burst_lo(2'b01, n, ilv_order)});
    rd(6'h0D);
    for (int n = 1; n < 4; n++) cyc(1, 3'b000, 1, '0, '0, '0, 1);
    idle(2);
    tag = "R8";
    wr(6'h20, 2'b11, 18'h2AAAA);
    rd(6'h20);
    rd(6'h20);
    tag = "R7";
    wr(6'h21, 2'b01, 18'h3FFFF);
    rd(6'h21);
    wr(6'h21, 2'b10, 18'h00000);
    rd(6'h21);
    tag = "R6";
    wr(6'h22, 2'b11, 18'h15555); rd(6'h20); wr(6'h20, 2'b11, 18'h0F0F0); rd(6'h22); rd(6'h20);
    idle(2);
    tag = "R11";
    cyc(0, 3'b111, 0, 6'h22, '0, '0, 0);
    cyc(0, 3'b000, 0, '0, '0, '0, 0);
    cyc(0, 3'b000, 0, '0, '0, '0, 1);
    tag = "R1";
    cyc(0, 3'b101, 1, 6'h22, 2'b11, 18'h00777, 1);
    cyc(0, 3'b011, 0, 6'h22, '0, '0, 1);
    cyc(1, 3'b111, 0, 6'h22, '0, '0, 1);
    idle(2);
    rd(6'h22);
    idle(2);
  endtask

  task automatic random_run(int n);
    tag = pipe_mode ? "R5" : "R4";
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 99);
      logic [2:0] cs = (r < 10) ? 3'($urandom_range(0, 6)) : 3'b111;
      cyc(r >= 80, cs, $urandom_range(0, 1) == 1, AW'($urandom), LN'($urandom),
          DW'($urandom), $urandom_range(0, 9) != 0);
    end
    idle(3);
  endtask

  initial begin
    process::self().srandom(32'h5EED);
    model_clear();
    phase(0, 0);
    for (int a = 0; a < DEP; a++) wr(AW'(a), 2'b11, DW'(a * 1237 + 5));
    idle(2);
    for (int p = 0; p < 4; p++) begin
      phase(p[0], p[1]);
      directed();
      random_run(400);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule